// File: doc/BRIEF.md
# Instruction Decoder with Immediate Prefix

This block takes a 32-bit instruction word and splits it into an opcode, three register indices and a 16-bit immediate. It also builds the second ALU operand, which is either the value of register rb or a 32-bit immediate formed from the 16-bit immediate field. The core's register file supplies the read data in the same cycle as the instruction. Indices that name r0 read as zero.

A dedicated prefix instruction stores its immediate as the upper half of a 32-bit constant. For the one instruction that follows it, an immediate operand is that stored upper half joined with the following instruction's own 16 bits. Without a pending prefix the 16-bit field is sign-extended. An all-zero word can be reported as an illegal-opcode request when two configuration inputs allow it. All outputs are registered and update one cycle after a valid instruction. Between valid instructions they hold their values.

Top module: `insn_decoder`

## Requirements
- R1: One cycle after a cycle with `insn_valid_i` high, the outputs carry opcode = word[31:26], rd = word[25:21], ra = word[20:16], rb = word[15:11] and imm = word[15:0]. `dec_valid_o` is high in exactly the cycles after such a cycle.
- R2: `type_b_o` equals word bit 29. When bit 29 is 0, operand B is the read data of rb.
- R3: A valid word whose opcode equals `PREFIX_OPC` (default 6'h2C) is flagged on `is_prefix_o`. It stores imm shifted left by 16 and sets a pending-prefix state. Its `rd_we_o` is low.
- R4: A type-B instruction that directly follows a prefix gets operand B = stored upper half OR zero-extended imm. Cycles with no valid word in between do not break this.
- R5: A type-B instruction with no pending prefix gets operand B = imm sign-extended to 32 bits.
- R6: The pending prefix is consumed by the next valid non-prefix instruction. An instruction after that one sees no prefix.
- R7: A prefix that follows a prefix replaces the stored upper half and keeps the prefix pending.
- R8: `illegal_o` is high for an all-zero word only when both `cfg_zero_illegal_i` and `cfg_exc_en_i` are high. An all-zero word still consumes a pending prefix.
- R9: Register index 0 reads as zero on operand A and on a type-A operand B, whatever the read data. `rd_we_o` is high only for a valid, legal, non-prefix instruction with rd != 0.
- R10: Reset clears every output to zero and drops any pending prefix.
- R11: In cycles without a valid word, all decoded outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| insn_valid_i | input | 1 | Instruction word is valid this cycle |
| ra_data_i | input | 32 | Register-file read data for index ra |
| rb_data_i | input | 32 | Register-file read data for index rb |
| cfg_zero_illegal_i | input | 1 | Treat an all-zero word as illegal |
| cfg_exc_en_i | input | 1 | Exceptions enabled |
| dec_valid_o | output | 1 | Decoded outputs refer to a new instruction |
| opcode_o | output | 6 | Opcode field |
| rd_o | output | 5 | Destination index |
| ra_o | output | 5 | Source A index |
| rb_o | output | 5 | Source B index |
| imm_o | output | 16 | Raw immediate field |
| type_b_o | output | 1 | Immediate form |
| is_prefix_o | output | 1 | Instruction was the prefix |
| opa_o | output | 32 | Operand A, zero for r0 |
| opb_o | output | 32 | Operand B |
| rd_we_o | output | 1 | Result may be written to rd |
| illegal_o | output | 1 | Illegal-opcode exception request |

## Verification
The bench aims at the prefix lifetime. It checks that the merge survives idle cycles, that it is applied to exactly one instruction, and that a second prefix replaces the first. A design that cleared the flag on idle cycles would sign-extend the merged constant. A design that kept the flag one instruction too long would corrupt the next immediate. Sign extension is probed with imm bit 15 set and cleared, so a design that zero-extends without a prefix, or sign-extends with one, shows the wrong upper half. The bench also tries the all-zero word under all four configuration combinations and r0 with non-zero read data, and resets with a prefix pending, where a design would otherwise leak a stale upper half.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int OPC_W  = 6;
  localparam int IDX_W  = 5;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  ra;
    logic [IDX_W-1:0]  rb;
    logic [HALF_W-1:0] imm;
    logic              type_b;
  } fields_t;

  function automatic logic [WORD_W-1:0] sext_half(input logic [HALF_W-1:0] v);
    return {{HALF_W{v[HALF_W-1]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] join_upper(input logic [WORD_W-1:0] held,
                                                   input logic [HALF_W-1:0] lo);
    return held | {{HALF_W{1'b0}}, lo};
  endfunction

  function automatic logic [WORD_W-1:0] gated_read(input logic [IDX_W-1:0] idx,
                                                   input logic [WORD_W-1:0] data);
    return (idx == '0) ? '0 : data;
  endfunction
endpackage

// File: rtl/insn_field_split.sv
module insn_field_split
  import insn_dec_pkg::*;
#(
  parameter logic [OPC_W-1:0] PREFIX_OPC = 6'h2C
) (
  input  logic [WORD_W-1:0] word_i,
  output fields_t           fields_o,
  output logic              is_prefix_o,
  output logic              is_zero_o
);
  localparam int OPC_LSB  = WORD_W - OPC_W;
  localparam int RD_LSB   = OPC_LSB - IDX_W;
  localparam int RA_LSB   = RD_LSB - IDX_W;
  localparam int RB_LSB   = RA_LSB - IDX_W;
  localparam int TYPE_BIT = WORD_W - 3;

  always_comb begin
    fields_o.opc    = word_i[OPC_LSB +: OPC_W];
    fields_o.rd     = word_i[RD_LSB +: IDX_W];
    fields_o.ra     = word_i[RA_LSB +: IDX_W];
    fields_o.rb     = word_i[RB_LSB +: IDX_W];
    fields_o.imm    = word_i[HALF_W-1:0];
    fields_o.type_b = word_i[TYPE_BIT];
  end

  assign is_prefix_o = (fields_o.opc == PREFIX_OPC);
  assign is_zero_o   = (word_i == '0);
endmodule

// File: rtl/imm_prefix_ctl.sv
module imm_prefix_ctl
  import insn_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              is_prefix_i,
  input  logic [HALF_W-1:0] imm_i,
  output logic              pending_o,
  output logic [WORD_W-1:0] held_o
);
  logic load_ev;
  logic consume_ev;

  assign load_ev    = accept_i && is_prefix_i;
  assign consume_ev = accept_i && !is_prefix_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_o <= 1'b0;
      held_o    <= '0;
    end else if (load_ev) begin
      pending_o <= 1'b1;
      held_o    <= {imm_i, {HALF_W{1'b0}}};
    end else if (consume_ev) begin
      pending_o <= 1'b0;
    end
  end

  a_r3_prefix_loads: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> pending_o && (held_o[WORD_W-1:HALF_W] == $past(imm_i)));
  a_r6_prefix_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    consume_ev |=> !pending_o);
  a_r4_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(pending_o) && $stable(held_o));
  a_r3_low_half_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o |-> held_o[HALF_W-1:0] == '0);
endmodule

// File: rtl/opb_select.sv
module opb_select
  import insn_dec_pkg::*;
(
  input  fields_t           fields_i,
  input  logic              pending_i,
  input  logic [WORD_W-1:0] held_i,
  input  logic [WORD_W-1:0] rb_data_i,
  output logic [WORD_W-1:0] opb_o
);
  logic [WORD_W-1:0] imm_ext;

  always_comb begin
    if (pending_i) imm_ext = join_upper(held_i, fields_i.imm);
    else           imm_ext = sext_half(fields_i.imm);
    opb_o = fields_i.type_b ? imm_ext : gated_read(fields_i.rb, rb_data_i);
  end

  always_comb begin
    a_r9_r0_opb: assert (fields_i.type_b || fields_i.rb != '0 || opb_o == '0);
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
#(
  parameter logic [5:0] PREFIX_OPC = 6'h2C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] insn_i,
  input  logic        insn_valid_i,
  input  logic [31:0] ra_data_i,
  input  logic [31:0] rb_data_i,
  input  logic        cfg_zero_illegal_i,
  input  logic        cfg_exc_en_i,
  output logic        dec_valid_o,
  output logic [5:0]  opcode_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  ra_o,
  output logic [4:0]  rb_o,
  output logic [15:0] imm_o,
  output logic        type_b_o,
  output logic        is_prefix_o,
  output logic [31:0] opa_o,
  output logic [31:0] opb_o,
  output logic        rd_we_o,
  output logic        illegal_o
);
  fields_t           f;
  logic              is_prefix;
  logic              is_zero;
  logic              pending;
  logic [WORD_W-1:0] held;
  logic [WORD_W-1:0] opb_next;
  logic              illegal_next;
  logic              we_next;

  insn_field_split #(.PREFIX_OPC(PREFIX_OPC)) u_split (
    .word_i      (insn_i),
    .fields_o    (f),
    .is_prefix_o (is_prefix),
    .is_zero_o   (is_zero)
  );

  imm_prefix_ctl u_prefix (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (insn_valid_i),
    .is_prefix_i (is_prefix),
    .imm_i       (f.imm),
    .pending_o   (pending),
    .held_o      (held)
  );

  opb_select u_opb (
    .fields_i  (f),
    .pending_i (pending),
    .held_i    (held),
    .rb_data_i (rb_data_i),
    .opb_o     (opb_next)
  );

  assign illegal_next = is_zero && cfg_zero_illegal_i && cfg_exc_en_i;
  assign we_next      = !is_prefix && !illegal_next && (f.rd != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      opcode_o    <= '0;
      rd_o        <= '0;
      ra_o        <= '0;
      rb_o        <= '0;
      imm_o       <= '0;
      type_b_o    <= 1'b0;
      is_prefix_o <= 1'b0;
      opa_o       <= '0;
      opb_o       <= '0;
      rd_we_o     <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      dec_valid_o <= insn_valid_i;
      if (insn_valid_i) begin
        opcode_o    <= f.opc;
        rd_o        <= f.rd;
        ra_o        <= f.ra;
        rb_o        <= f.rb;
        imm_o       <= f.imm;
        type_b_o    <= f.type_b;
        is_prefix_o <= is_prefix;
        opa_o       <= gated_read(f.ra, ra_data_i);
        opb_o       <= opb_next;
        rd_we_o     <= we_next;
        illegal_o   <= illegal_next;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_i |=> dec_valid_o);
  a_r11_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid_i |=> !dec_valid_o && $stable(opb_o) && $stable(opcode_o));
  a_r1_opcode_field: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_i |=> opcode_o == $past(insn_i[31:26]));
  a_r8_zero_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_i && insn_i == '0 && cfg_zero_illegal_i && cfg_exc_en_i |=> illegal_o);
  a_r8_nonzero_legal: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_i && insn_i != '0 |=> !illegal_o);
  a_r9_r0_opa: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o && ra_o == '0 |-> opa_o == '0);
  a_r9_we_rule: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> !is_prefix_o && !illegal_o && rd_o != '0);
endmodule

// File: tb/insn_decoder_bench.sv
module insn_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn_i = '0;
  logic        insn_valid_i = 1'b0;
  logic [31:0] ra_data_i = '0;
  logic [31:0] rb_data_i = '0;
  logic        cfg_zero_illegal_i = 1'b0;
  logic        cfg_exc_en_i = 1'b0;
  logic        dec_valid_o, type_b_o, is_prefix_o, rd_we_o, illegal_o;
  logic [5:0]  opcode_o;
  logic [4:0]  rd_o, ra_o, rb_o;
  logic [15:0] imm_o;
  logic [31:0] opa_o, opb_o;

  localparam logic [5:0] PFX = 6'h2C;

  insn_decoder u_insn_decoder (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic        m_pend = 0;
  logic [15:0] m_hi = '0;
  logic [31:0] last_opb = '0;
  logic [5:0]  last_opc = '0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_opb(input logic [31:0] w, input logic pend,
                                          input logic [15:0] hi, input logic [31:0] rbd);
    logic signed [31:0] s;
    if (!w[29]) return (w[15:11] == 5'd0) ? 32'd0 : rbd;
    if (pend) return {hi, w[15:0]};
    s = 32'($signed(w[15:0]));
    return s;
  endfunction

  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] da,
                      input logic [31:0] db, input logic zi, input logic ee);
    logic [31:0] e_opb;
    logic e_ill, e_pfx, e_we;
    e_opb = ref_opb(w, m_pend, m_hi, db);
    e_ill = (w == 32'd0) && zi && ee;
    e_pfx = (w[31:26] == PFX);
    e_we  = !e_pfx && !e_ill && (w[25:21] != 5'd0);
    @(negedge clk);
    insn_i = w; insn_valid_i = v; ra_data_i = da; rb_data_i = db;
    cfg_zero_illegal_i = zi; cfg_exc_en_i = ee;
    @(posedge clk);
    #2;
    insn_valid_i = 1'b0;
    chk("R1 valid", 32'(dec_valid_o), 32'(v));
    if (v) begin
      chk("R1 opcode", 32'(opcode_o), 32'(w[31:26]));
      chk("R1 rd", 32'(rd_o), 32'(w[25:21]));
      chk("R1 ra", 32'(ra_o), 32'(w[20:16]));
      chk("R1 rb", 32'(rb_o), 32'(w[15:11]));
      chk("R1 imm", 32'(imm_o), 32'(w[15:0]));
      chk("R2 type_b", 32'(type_b_o), 32'(w[29]));
      chk("R3 is_prefix", 32'(is_prefix_o), 32'(e_pfx));
      chk(w[29] ? (m_pend ? "R4 merged opb" : "R5 sext opb") : "R2 reg opb", opb_o, e_opb);
      chk("R9 opa", opa_o, (w[20:16] == 5'd0) ? 32'd0 : da);
      chk("R9 rd_we", 32'(rd_we_o), 32'(e_we));
      chk("R8 illegal", 32'(illegal_o), 32'(e_ill));
      if (e_pfx) begin m_pend = 1; m_hi = w[15:0]; end
      else m_pend = 0;
      last_opb = e_opb; last_opc = w[31:26];
    end else begin
      chk("R11 opb held", opb_o, last_opb);
      chk("R11 opcode held", 32'(opcode_o), 32'(last_opc));
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rd,
                                     input logic [4:0] ra, input logic [4:0] rb,
                                     input logic [10:0] lo);
    return {opc, rd, ra, rb, lo};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset valid", 32'(dec_valid_o), 0);
    chk("R10 reset opb", opb_o, 0);
    chk("R10 reset opcode", 32'(opcode_o), 0);
    @(negedge clk); rst_n = 1'b1;
    // R5: no prefix after reset, negative and positive immediates
    step(1, {6'h28, 5'd3, 5'd4, 16'h8001}, 32'h11, 32'h22, 0, 0);
    step(1, {6'h28, 5'd3, 5'd4, 16'h7FFF}, 32'h11, 32'h22, 0, 0);
    // R3/R4: prefix then merged with negative low half
    step(1, {PFX, 5'd0, 5'd0, 16'hDEAD}, 0, 0, 0, 0);
    step(1, {6'h28, 5'd1, 5'd2, 16'h8765}, 32'h5, 0, 0, 0);
    // R6: next one sign-extended
    step(1, {6'h28, 5'd1, 5'd2, 16'h8765}, 32'h5, 0, 0, 0);
    // R4: idle gap keeps prefix
    step(1, {PFX, 5'd0, 5'd0, 16'h1234}, 0, 0, 0, 0);
    step(0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(0, 32'h0, 0, 0, 0, 0);
    step(1, {6'h28, 5'd7, 5'd2, 16'hF00F}, 0, 0, 0, 0);
    // R7: double prefix replaces
    step(1, {PFX, 5'd0, 5'd0, 16'hAAAA}, 0, 0, 0, 0);
    step(1, {PFX, 5'd0, 5'd0, 16'h0055}, 0, 0, 0, 0);
    step(1, {6'h28, 5'd7, 5'd2, 16'h9000}, 0, 0, 0, 0);
    // R6: type-A instruction consumes prefix
    step(1, {PFX, 5'd0, 5'd0, 16'hBEEF}, 0, 0, 0, 0);
    step(1, mk(6'h00, 5'd2, 5'd3, 5'd4, 0), 32'h33, 32'h44, 0, 0);
    step(1, {6'h28, 5'd7, 5'd2, 16'h9000}, 0, 0, 0, 0);
    // R8: zero word under four configurations; also consumes prefix
    step(1, {PFX, 5'd0, 5'd0, 16'h4444}, 0, 0, 0, 0);
    step(1, 32'h0, 32'h1, 32'h2, 1, 1);
    step(1, {6'h28, 5'd7, 5'd2, 16'h0001}, 0, 0, 0, 0);
    step(1, 32'h0, 32'h1, 32'h2, 1, 0);
    step(1, 32'h0, 32'h1, 32'h2, 0, 1);
    step(1, 32'h0, 32'h1, 32'h2, 0, 0);
    // R9: r0 reads zero
    step(1, mk(6'h00, 5'd0, 5'd0, 5'd0, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    step(1, mk(6'h00, 5'd9, 5'd0, 5'd8, 0), 32'hCAFE, 32'hF00D, 0, 0);
    // R10: reset with pending prefix drops it
    step(1, {PFX, 5'd0, 5'd0, 16'h7777}, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b0; m_pend = 0; m_hi = '0;
    last_opb = '0; last_opc = '0;
    #1 chk("R10 reset mid-run opb", opb_o, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1, {6'h28, 5'd7, 5'd2, 16'h0002}, 0, 0, 0, 0);
    // random traffic, R1-R9 and R11
    void'($urandom(32'h5EED));
    for (int i = 0; i < 3000; i++) begin
      w = $urandom;
      case ($urandom_range(0, 7))
        0, 1: w[31:26] = PFX;
        2: w = 32'h0;
        3: w[20:11] = '0;
        default: ;
      endcase
      step(($urandom_range(0, 4) != 0), w, $urandom, $urandom,
           1'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule